// File: doc/BRIEF.md
# Clear-on-Read Interrupt Flag Controller

This block gathers three interrupt event sources: alarm, periodic and update-ended. Each source arrives as a single-cycle pulse. Each pulse sets a sticky flag whether or not the source is enabled, so software can poll the flags with interrupts disabled.

A control word holds one enable bit per source. The active-low request output is asserted while any flag and its enable are both 1. Setting an enable over a flag that is already pending asserts the request on the next edge.

Software reads the status word through a level-held read strobe. At the start of a status read, the flags are frozen into a hold register. The bus shows that held value unchanged for as long as the strobe stays high. When the strobe drops, the flags that were returned are cleared. Any pulse that arrived during the read is parked in a per-source pending bit and merged into the flags at the end of the read, so no event is lost.

Top module: `irq_flag_ctl`

## Requirements
- R1: After reset every flag and every enable is 0, `irq_n` is 1 and `bus_rdata` is 0.
- R2: A pulse on `evt_alarm`, `evt_periodic` or `evt_update` outside a status read sets that source's flag, whatever its enable.
- R3: `irq_n` is 0 exactly while some source has both its flag and its enable at 1; a source whose enable is 0 never pulls `irq_n` low.
- R4: A control write that sets the enable of a source whose flag is already 1 makes `irq_n` 0 in the cycle after the write edge.
- R5: Read layout. The status word (address 0) has the request summary in bit 7, the periodic flag in bit 6, the alarm flag in bit 5, the update flag in bit 4, and zeros in bits 3..0. The control word (address 1) has the periodic, alarm and update enables in bits 6, 5 and 4 and zeros elsewhere. Addresses 2 and 3 read as 0.
- R6: `bus_rdata` shows the word captured at the edge where `bus_rd` is first sampled high. It holds that word unchanged until the edge where `bus_rd` is sampled low, after which it reads 0.
- R7: When a status read ends, every flag returned by that read is cleared.
- R8: A pulse arriving between the start edge and the end edge of a status read (both edges included) is absent from the returned word. It is set in the flags after the read ends.
- R9: Writes to the status address change nothing. Control writes store only bits 6..4 of `bus_wdata`.
- R10: One, two or all three flags can be returned together in a single status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_alarm | input | 1 | Alarm event pulse |
| evt_periodic | input | 1 | Periodic event pulse |
| evt_update | input | 1 | Update-ended event pulse |
| bus_rd | input | 1 | Read strobe, held high for the whole read |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when no read is in progress |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Two functions can land on the same edge: an event pulse, and the start or end of a status read. The bench provokes this directly by pulsing the update source inside a long read. It also runs a random phase where pulses, reads of random length and writes overlap freely. The result is judged against a behavioural model that parks mid-read events in a queue and drains it when the strobe falls. The model is compared with both outputs on every clock, so an event that is lost or returned too early shows up as a mismatch in a later read.

// File: rtl/irq_flag_pkg.sv
// Package: shared constants and types for the interrupt flag controller.
// Assumes source index 0 = update, 1 = alarm, 2 = periodic.
package irq_flag_pkg;
    localparam int NUM_SRC = 3;
    localparam int SRC_UPD = 0;
    localparam int SRC_ALM = 1;
    localparam int SRC_PER = 2;

    typedef enum logic [1:0] {
        RD_IDLE   = 2'd0,
        RD_STATUS = 2'd1,
        RD_OTHER  = 2'd2
    } rd_state_e;
endpackage

// File: rtl/irq_src_latch.sv
// Module: one sticky flag plus one deferral bit for a single event source.
// Assumes evt is a one-cycle pulse. While defer_en is high, pulses are parked
// in the pending bit and the flag is frozen. On merge_en the flag is replaced
// by the parked pulses (the returned flags are thereby cleared).
module irq_src_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic defer_en,
    input  logic merge_en,
    output logic flag
);
    logic flag_q;
    logic pend_q;

    // Flag and pending bit update: merge, defer, or accumulate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            pend_q <= 1'b0;
        end else if (merge_en) begin
            flag_q <= pend_q | evt;
            pend_q <= 1'b0;
        end else if (defer_en) begin
            pend_q <= pend_q | evt;
        end else begin
            flag_q <= flag_q | evt;
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/irq_ctrl_reg.sv
// Module: enable bits of the control word.
// Assumes one write strobe per access. Only the enable field is stored.
module irq_ctrl_reg #(
    parameter int ADDR_W    = 2,
    parameter int DATA_W    = 8,
    parameter int CTRL_ADDR = 1,
    parameter int FLAG_LSB  = 4,
    parameter int NUM_SRC   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [NUM_SRC-1:0] en
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    logic [NUM_SRC-1:0] en_q;
    logic               hit;

    // Address decode of the control word.
    assign hit = wr && (addr == CTRL_A);

    // Enable storage, written only on a control-address hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (hit) begin
            en_q <= wdata[FLAG_LSB +: NUM_SRC];
        end
    end

    assign en = en_q;
endmodule

// File: rtl/irq_read_port.sv
// Module: read handshake sequencer and hold register.
// Assumes rd_req stays high for the whole read and drops for at least one
// cycle between reads. It captures the addressed word at the start edge and
// tells the flag latches when to defer events and when to merge them.
module irq_read_port
    import irq_flag_pkg::*;
#(
    parameter int ADDR_W      = 2,
    parameter int DATA_W      = 8,
    parameter int STATUS_ADDR = 0,
    parameter int CTRL_ADDR   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] status_word,
    input  logic [DATA_W-1:0] ctrl_word,
    output logic [DATA_W-1:0] rdata,
    output logic              defer_evt,
    output logic              merge_evt
);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_ADDR);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    rd_state_e         state_q;
    rd_state_e         state_d;
    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] pick_word;
    logic              start;
    logic              hit_stat;

    // Start of a read, and whether it targets the status word.
    assign start    = (state_q == RD_IDLE) && rd_req;
    assign hit_stat = (addr == STAT_A);

    // Word selected for capture at the start edge.
    always_comb begin
        if (hit_stat)
            pick_word = status_word;
        else if (addr == CTRL_A)
            pick_word = ctrl_word;
        else
            pick_word = '0;
    end

    // Next-state logic of the read sequencer.
    always_comb begin
        state_d = state_q;
        case (state_q)
            RD_IDLE:   if (rd_req) state_d = hit_stat ? RD_STATUS : RD_OTHER;
            RD_STATUS: if (!rd_req) state_d = RD_IDLE;
            RD_OTHER:  if (!rd_req) state_d = RD_IDLE;
            default:   state_d = RD_IDLE;
        endcase
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    // Hold register, loaded once per read.
    always_ff @(posedge clk) begin
        if (!rst_n)     hold_q <= '0;
        else if (start) hold_q <= pick_word;
    end

    // Deferral covers the start edge through the last high cycle; merge is the end edge.
    assign defer_evt = (start && hit_stat) || (state_q == RD_STATUS && rd_req);
    assign merge_evt = (state_q == RD_STATUS) && !rd_req;

    // Bus output is the held word while a read is in progress.
    assign rdata = (state_q != RD_IDLE) ? hold_q : '0;
endmodule

// File: rtl/irq_flag_ctl.sv
// Module: top of the clear-on-read interrupt flag controller.
// Assumes event inputs are single-cycle pulses synchronous to clk. It combines
// per-source flag latches, the enable register and the read sequencer, and
// drives the active-low request.
module irq_flag_ctl
    import irq_flag_pkg::*;
#(
    parameter int ADDR_W      = 2,
    parameter int DATA_W      = 8,
    parameter int STATUS_ADDR = 0,
    parameter int CTRL_ADDR   = 1,
    parameter int FLAG_LSB    = 4,
    parameter int SUM_BIT     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_alarm,
    input  logic              evt_periodic,
    input  logic              evt_update,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_n
);
    localparam int FLAG_MSB = FLAG_LSB + NUM_SRC - 1;

    logic [NUM_SRC-1:0] evt_vec;
    logic [NUM_SRC-1:0] flag_vec;
    logic [NUM_SRC-1:0] en_vec;
    logic [DATA_W-1:0]  status_word;
    logic [DATA_W-1:0]  ctrl_word;
    logic               defer_evt;
    logic               merge_evt;
    logic               req_any;
    logic               unused_wdata;

    // Event pulses packed in source-index order.
    always_comb begin
        evt_vec          = '0;
        evt_vec[SRC_UPD] = evt_update;
        evt_vec[SRC_ALM] = evt_alarm;
        evt_vec[SRC_PER] = evt_periodic;
    end

    // One flag latch per source.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        irq_src_latch u_latch (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt      (evt_vec[i]),
            .defer_en (defer_evt),
            .merge_en (merge_evt),
            .flag     (flag_vec[i])
        );
    end

    irq_ctrl_reg #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CTRL_ADDR (CTRL_ADDR),
        .FLAG_LSB  (FLAG_LSB),
        .NUM_SRC   (NUM_SRC)
    ) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .en    (en_vec)
    );

    // Request condition: any flag gated by its enable.
    assign req_any = |(flag_vec & en_vec);

    // Status word assembly: summary bit plus flag field.
    always_comb begin
        status_word                      = '0;
        status_word[SUM_BIT]             = req_any;
        status_word[FLAG_MSB:FLAG_LSB]   = flag_vec;
    end

    // Control word assembly: enable field only.
    always_comb begin
        ctrl_word                    = '0;
        ctrl_word[FLAG_MSB:FLAG_LSB] = en_vec;
    end

    irq_read_port #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .STATUS_ADDR (STATUS_ADDR),
        .CTRL_ADDR   (CTRL_ADDR)
    ) u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_req      (bus_rd),
        .addr        (bus_addr),
        .status_word (status_word),
        .ctrl_word   (ctrl_word),
        .rdata       (bus_rdata),
        .defer_evt   (defer_evt),
        .merge_evt   (merge_evt)
    );

    // Active-low request output.
    assign irq_n = ~req_any;

    // Write data outside the enable field is not stored.
    assign unused_wdata = ^bus_wdata;
endmodule

// File: rtl/irq_flag_chk.sv
// Checker: temporal properties of the flag controller, bound to its top.
module irq_flag_chk #(
    parameter int ADDR_W      = 2,
    parameter int DATA_W      = 8,
    parameter int STATUS_ADDR = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              evt_alarm,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_n,
    input logic [2:0]        flags,
    input logic [2:0]        enables
);
    // R3: a low request always has some enable behind it.
    p_enable_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (enables != 3'b000));

    // R6: read data is frozen once a read has been held for two edges.
    p_rdata_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && $past(bus_rd) && $past(bus_rd, 2)) |-> $stable(bus_rdata));

    // R6: no read in progress means zero on the bus.
    p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd && !$past(bus_rd)) |-> (bus_rdata == '0));

    // R2: an alarm pulse outside any read sets the alarm flag.
    p_alarm_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_alarm && !bus_rd && !$past(bus_rd)) |=> flags[1]);

    // R9: writes to the status address leave the enables alone.
    p_status_wr_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(STATUS_ADDR)) |=> $stable(enables));
endmodule

bind irq_flag_ctl irq_flag_chk #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .STATUS_ADDR (STATUS_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_alarm (evt_alarm),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq_n     (irq_n),
    .flags     (flag_vec),
    .enables   (en_vec)
);

// File: tb/tb_irq_flag_ctl.sv
module tb_irq_flag_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_alarm = 0, evt_periodic = 0, evt_update = 0;
    logic       bus_rd = 0, bus_wr = 0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_n;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    irq_flag_ctl dut (
        .clk(clk), .rst_n(rst_n), .evt_alarm(evt_alarm), .evt_periodic(evt_periodic),
        .evt_update(evt_update), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural model: bits {periodic, alarm, update}; parked events kept in a queue.
    logic [2:0] m_flag, m_en, m_hold_f;
    logic [7:0] m_hold;
    bit         m_busy, m_stat;
    logic [2:0] m_park[$];

    always @(posedge clk) begin
        logic [2:0] ev;
        bit         req;
        ev  = {evt_periodic, evt_alarm, evt_update};
        req = |(m_flag & m_en);
        if (!rst_n) begin
            m_flag = 0; m_en = 0; m_busy = 0; m_stat = 0; m_hold = 0; m_park.delete();
        end else begin
            if (!m_busy) begin
                if (bus_rd) begin
                    m_busy = 1;
                    m_stat = (bus_addr == 2'd0);
                    if (m_stat) begin
                        m_hold = {req, m_flag, 4'b0};
                        m_park.push_back(ev);
                    end else begin
                        m_hold = (bus_addr == 2'd1) ? {1'b0, m_en, 4'b0} : 8'h00;
                        m_flag = m_flag | ev;
                    end
                end else begin
                    m_flag = m_flag | ev;
                end
            end else if (bus_rd) begin
                if (m_stat) m_park.push_back(ev);
                else        m_flag = m_flag | ev;
            end else begin
                m_busy = 0;
                if (m_stat) begin
                    m_flag = ev;
                    foreach (m_park[k]) m_flag = m_flag | m_park[k];
                    m_park.delete();
                end else begin
                    m_flag = m_flag | ev;
                end
            end
            if (bus_wr && bus_addr == 2'd1) m_en = bus_wdata[6:4];
        end
    end

    // Per-clock comparison of both outputs against the model (R3, R6).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [7:0] exp_rd;
            exp_rd = m_busy ? m_hold : 8'h00;
            compared++;
            if (bus_rdata !== exp_rd) begin
                mismatched++;
                $display("FAIL R6 model rdata at %0t: actual %02h expected %02h", $time, bus_rdata, exp_rd);
            end
            compared++;
            if (irq_n !== !(|(m_flag & m_en))) begin
                mismatched++;
                $display("FAIL R3 model irq_n at %0t: actual %0b expected %0b", $time, irq_n, !(|(m_flag & m_en)));
            end
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic pulse(input bit p, input bit a, input bit u);
        evt_periodic = p; evt_alarm = a; evt_update = u;
        @(negedge clk);
        evt_periodic = 0; evt_alarm = 0; evt_update = 0;
    endtask

    // Read held for len cycles; an update pulse is injected in cycle inj (-1 for none).
    task automatic read_reg(input logic [1:0] a, input int len, input int inj, output logic [7:0] val);
        bus_rd = 1; bus_addr = a;
        if (inj == 0) evt_update = 1;
        @(negedge clk);
        evt_update = 0;
        val = bus_rdata;
        for (int k = 1; k < len; k++) begin
            if (inj == k) evt_update = 1;
            @(negedge clk);
            evt_update = 0;
            check("R6 held read value", bus_rdata, val);
        end
        bus_rd = 0;
        @(negedge clk);
    endtask

    initial begin
        #(WATCHDOG * CLK_PERIOD);
        mismatched++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 irq_n after reset", {7'b0, irq_n}, 8'h01);
        check("R1 rdata after reset", bus_rdata, 8'h00);
        read_reg(2'd0, 2, -1, v);
        check("R1 status after reset", v, 8'h00);

        // R2/R3: alarm with enables off sets flag, no request.
        pulse(0, 1, 0);
        check("R3 disabled source keeps irq_n high", {7'b0, irq_n}, 8'h01);
        read_reg(2'd0, 3, -1, v);
        check("R2 R5 alarm flag in bit 5", v, 8'h20);
        read_reg(2'd0, 1, -1, v);
        check("R7 flag cleared after read", v, 8'h00);

        // R4: enable over a pending periodic flag.
        pulse(1, 0, 0);
        check("R3 before enable", {7'b0, irq_n}, 8'h01);
        write_reg(2'd1, 8'h40);
        check("R4 irq_n low after enable write", {7'b0, irq_n}, 8'h00);
        read_reg(2'd0, 2, -1, v);
        check("R5 summary and periodic bits", v, 8'hC0);
        check("R7 request released after read", {7'b0, irq_n}, 8'h01);

        // R10: all three flags in one read.
        write_reg(2'd1, 8'h70);
        pulse(1, 1, 1);
        read_reg(2'd0, 2, -1, v);
        check("R10 three flags together", v, 8'hF0);

        // R8: update pulse on the start edge and in the middle of a read.
        pulse(0, 1, 0);
        read_reg(2'd0, 4, 2, v);
        check("R8 mid-read pulse excluded", v, 8'hA0);
        check("R8 deferred pulse raises request", {7'b0, irq_n}, 8'h00);
        read_reg(2'd0, 2, -1, v);
        check("R8 deferred update applied", v, 8'h90);
        read_reg(2'd0, 3, 0, v);
        check("R8 start-edge pulse excluded", v, 8'h00);
        read_reg(2'd0, 1, -1, v);
        check("R8 start-edge pulse applied", v, 8'h90);

        // R9/R5: status write ignored, control keeps only enable field.
        write_reg(2'd1, 8'h20);
        write_reg(2'd0, 8'hFF);
        read_reg(2'd1, 2, -1, v);
        check("R9 status write ignored", v, 8'h20);
        write_reg(2'd1, 8'hFF);
        read_reg(2'd1, 1, -1, v);
        check("R9 R5 control field only", v, 8'h70);
        read_reg(2'd2, 2, -1, v);
        check("R5 unmapped address", v, 8'h00);

        // Random overlap of pulses, reads and writes, judged by the model.
        begin
            int rd_left;
            rd_left = 0;
            for (int n = 0; n < 4000; n++) begin
                evt_alarm    = ($urandom_range(0, 5) == 0);
                evt_periodic = ($urandom_range(0, 5) == 0);
                evt_update   = ($urandom_range(0, 5) == 0);
                bus_wr = ($urandom_range(0, 9) == 0);
                bus_wdata = 8'($urandom);
                if (rd_left > 0) begin
                    rd_left--;
                end else if (bus_rd) begin
                    bus_rd = 0;
                end else if ($urandom_range(0, 3) == 0) begin
                    bus_rd = 1;
                    bus_addr = 2'($urandom_range(0, 3));
                    rd_left = $urandom_range(0, 4);
                end
                if (bus_wr && !bus_rd) bus_addr = 2'($urandom_range(0, 3));
                @(negedge clk);
            end
            evt_alarm = 0; evt_periodic = 0; evt_update = 0; bus_wr = 0; bus_rd = 0;
            repeat (3) @(negedge clk);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule